// File: doc/BRIEF.md
# Serial-Unlock Shadow Register Access Controller

This controller guards a hidden 64-bit timekeeping register file that shares a byte-wide asynchronous memory bus with an ordinary RAM. It samples the bus strobes on its own clock and treats each bus cycle as an event. Chip-enable together with write-enable makes a write. Chip-enable together with output-enable, with write-enable inactive, makes a read. While the controller is idle, every cycle goes to memory. Writes are compared, one bit per cycle on data bit 0, against a fixed 64-bit unlock key.

Once all 64 key bits have matched in sequence, the controller takes a snapshot of the register file and holds the memory-inhibit output high. It then serves exactly 64 further bus cycles. Each one either presents the next register bit on the read-data output or accepts a new bit from data bit 0. The order runs from bit 0 of the first register byte up to bit 7 of the last. When a transfer that contained at least one write completes, the whole 64-bit image is committed at once with a single-cycle strobe. A low level on the external reset pin aborts a transfer without committing anything, unless the reset-enable flag from the register file says to ignore the pin.

Top module: `serial_unlock_ctrl`

## Requirements
- R1: After synchronous reset, mem_block, wr_strobe and rd_bit are all 0.
- R2: The key is the 64-bit value 64'h5CA33AC55CA33AC5, taken from bit 0 upward. Key bit k is compared with dq0 on the k-th write after a read. Once all 64 bits have matched, mem_block goes to 1.
- R3: A mismatching write leaves the pointer frozen, and all later writes are ignored until a read. A complete correct key sent after a mismatch, with no read in between, does not unlock.
- R4: A read cycle while idle returns the pointer to key bit 0. A fresh full key after a read unlocks, whatever partial sequence came before.
- R5: While idle, and while key writes are in progress, mem_block stays 0.
- R6: In a transfer, before its i-th cycle rd_bit shows bit i of regs_in as sampled when the key completed. Later changes of regs_in do not alter the bits read out. rd_bit is 0 outside a transfer.
- R7: A transfer of 64 writes produces exactly one wr_strobe pulse of one clock, at the end. In the committed wr_data, bit i is the dq0 value of the i-th transfer cycle.
- R8: In a mixed transfer, each read cycle keeps the snapshot bit at its position in wr_data. A transfer made only of reads produces no wr_strobe.
- R9: With rst_en_ignore = 0, rst_pin_n low during a transfer aborts it. No wr_strobe is produced, and mem_block returns to 0.
- R10: With rst_en_ignore = 1, rst_pin_n is ignored. The transfer runs to 64 cycles and commits.
- R11: A cycle counts only when chip-enable is low. A write strobe with chip-enable high neither advances nor disturbs the key match.
- R12: After the 64th transfer cycle, mem_block stays 1 until the bus strobes are released, then drops to 0. The pointer is back at key bit 0, so a new key unlocks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| dq0 | input | 1 | Data bus bit 0 |
| rst_pin_n | input | 1 | External abort pin, active low |
| rst_en_ignore | input | 1 | 1: abort pin is ignored |
| regs_in | input | 64 | Current timekeeping register image |
| mem_block | output | 1 | Inhibit memory access during a transfer |
| rd_bit | output | 1 | Register bit driven onto data bit 0 |
| wr_data | output | 64 | Committed register image |
| wr_strobe | output | 1 | One-cycle commit pulse for wr_data |

## Verification
The hardest state to reach is the sticky mismatch. Here a wrong bit must freeze the pointer, and a complete valid key sent afterwards must still fail to unlock. Only a read can revive the match. The stimulus deliberately corrupts one key bit partway through, sends a full correct key with no read, and confirms that mem_block never rises. It then issues one read and repeats the key. A second hard case is an abort in the middle of a transfer. The bench pulls the reset pin low after some of the transfer writes and observes that no commit appears. It then shows that the block accepts a new key.

// File: rtl/sulk_pkg.sv
package sulk_pkg;
  localparam int unsigned KEY_W  = 64;
  localparam int unsigned XFER_W = 64;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 64'h5CA33AC5_5CA33AC5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/sulk_bus_sampler.sv
module sulk_bus_sampler (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic dq0,
  input  logic rst_pin_n,
  output logic d0_s,
  output logic hold_n_s,
  output logic acc_any,
  output logic wr_evt,
  output logic rd_evt
);
  logic cs_n_s, oe_n_s, we_n_s, acc_prev;
  logic acc_wr, acc_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_s   <= 1'b1;
      oe_n_s   <= 1'b1;
      we_n_s   <= 1'b1;
      d0_s     <= 1'b0;
      hold_n_s <= 1'b1;
      acc_prev <= 1'b0;
    end else begin
      cs_n_s   <= cs_n;
      oe_n_s   <= oe_n;
      we_n_s   <= we_n;
      d0_s     <= dq0;
      hold_n_s <= rst_pin_n;
      acc_prev <= acc_any;
    end
  end

  // Write takes priority over output enable when both are low.
  assign acc_wr  = ~cs_n_s & ~we_n_s;
  assign acc_rd  = ~cs_n_s & ~oe_n_s & we_n_s;
  assign acc_any = acc_wr | acc_rd;
  assign wr_evt  = acc_wr & ~acc_prev;
  assign rd_evt  = acc_rd & ~acc_prev;
endmodule

// File: rtl/sulk_key_matcher.sv
module sulk_key_matcher #(
  parameter int unsigned         KW  = 64,
  parameter logic [KW-1:0]       KEY = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wr_evt,
  input  logic rd_evt,
  input  logic d0,
  output logic unlock
);
  localparam int unsigned PW = $clog2(KW);
  localparam logic [PW-1:0] PLAST = PW'(KW - 1);

  logic [PW-1:0] ptr;
  logic          fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      fail   <= 1'b0;
      unlock <= 1'b0;
    end else begin
      unlock <= 1'b0;
      if (en) begin
        if (rd_evt) begin
          ptr  <= '0;
          fail <= 1'b0;
        end else if (wr_evt && !fail) begin
          if (d0 == KEY[ptr]) begin
            if (ptr == PLAST) begin
              ptr    <= '0;
              unlock <= 1'b1;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end else begin
            fail <= 1'b1;
          end
        end
      end
    end
  end

  // R4: a read while idle always rewinds the comparison pointer.
  assert_read_rewinds_R4: assert property (@(posedge clk) disable iff (rst)
    (en && rd_evt) |=> (ptr == '0));

  // R3: after a mismatch the pointer does not move until a read.
  assert_fail_freezes_R3: assert property (@(posedge clk) disable iff (rst)
    (en && fail && !rd_evt) |=> $stable(ptr));
endmodule

// File: rtl/sulk_xfer_engine.sv
module sulk_xfer_engine #(
  parameter int unsigned XW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unlock,
  input  logic          wr_evt,
  input  logic          rd_evt,
  input  logic          acc_any,
  input  logic          d0,
  input  logic          hold_n,
  input  logic          hold_ignore,
  input  logic [XW-1:0] regs_in,
  output logic          idle,
  output logic          mem_block,
  output logic          rd_bit,
  output logic [XW-1:0] wr_data,
  output logic          wr_strobe
);
  import sulk_pkg::*;
  localparam int unsigned IW = $clog2(XW);
  localparam logic [IW-1:0] ILAST = IW'(XW - 1);

  xfer_state_t   state;
  logic [IW-1:0] idx;
  logic [XW-1:0] shreg, nxt;
  logic          wrote, evt, abort;

  assign evt   = wr_evt | rd_evt;
  assign abort = ~hold_ignore & ~hold_n;
  // Rotate: bit 0 leaves, re-enters at the top (read) or is replaced (write).
  assign nxt   = {(wr_evt ? d0 : shreg[0]), shreg[XW-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      shreg     <= '0;
      wrote     <= 1'b0;
      wr_strobe <= 1'b0;
      wr_data   <= '0;
    end else begin
      wr_strobe <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (unlock) begin
            state <= ST_XFER;
            shreg <= regs_in;
            idx   <= '0;
            wrote <= 1'b0;
          end
        end
        ST_XFER: begin
          if (abort) begin
            state <= ST_DRAIN;
            idx   <= '0;
          end else if (evt) begin
            shreg <= nxt;
            if (idx == ILAST) begin
              state     <= ST_DRAIN;
              idx       <= '0;
              wr_strobe <= wrote | wr_evt;
              wr_data   <= nxt;
            end else begin
              idx   <= idx + 1'b1;
              wrote <= wrote | wr_evt;
            end
          end
        end
        ST_DRAIN: begin
          if (!acc_any) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state == ST_IDLE);
  assign mem_block = (state != ST_IDLE);
  assign rd_bit    = (state == ST_XFER) & shreg[0];

  // R2: the inhibit only rises right after a completed key.
  assert_enter_on_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_block) |-> $past(unlock));

  // R7: the commit is a single-clock pulse.
  assert_commit_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);

  // R9: an abort never produces a commit.
  assert_abort_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER && abort) |=> !wr_strobe);

  // R6: the bit position only moves on a bus cycle.
  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER && !evt && !abort) |=> $stable(idx));
endmodule

// File: rtl/serial_unlock_ctrl.sv
module serial_unlock_ctrl #(
  parameter int unsigned               KEY_W = sulk_pkg::KEY_W,
  parameter int unsigned               XW    = sulk_pkg::XFER_W,
  parameter logic [KEY_W-1:0]          KEY   = sulk_pkg::UNLOCK_KEY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          dq0,
  input  logic          rst_pin_n,
  input  logic          rst_en_ignore,
  input  logic [XW-1:0] regs_in,
  output logic          mem_block,
  output logic          rd_bit,
  output logic [XW-1:0] wr_data,
  output logic          wr_strobe
);
  logic d0_s, hold_n_s, acc_any, wr_evt, rd_evt;
  logic unlock, idle;

  sulk_bus_sampler u_sampler (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .dq0(dq0), .rst_pin_n(rst_pin_n), .d0_s(d0_s), .hold_n_s(hold_n_s),
    .acc_any(acc_any), .wr_evt(wr_evt), .rd_evt(rd_evt)
  );

  sulk_key_matcher #(.KW(KEY_W), .KEY(KEY)) u_matcher (
    .clk(clk), .rst(rst), .en(idle), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .d0(d0_s), .unlock(unlock)
  );

  sulk_xfer_engine #(.XW(XW)) u_engine (
    .clk(clk), .rst(rst), .unlock(unlock), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .acc_any(acc_any), .d0(d0_s), .hold_n(hold_n_s),
    .hold_ignore(rst_en_ignore), .regs_in(regs_in), .idle(idle),
    .mem_block(mem_block), .rd_bit(rd_bit), .wr_data(wr_data),
    .wr_strobe(wr_strobe)
  );
endmodule

// File: tb/test_serial_unlock_ctrl.sv
module test_serial_unlock_ctrl;
  localparam logic [63:0] KEYV = 64'h5CA33AC5_5CA33AC5;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dq0 = 1'b0;
  logic rst_pin_n = 1'b1, rst_en_ignore = 1'b0;
  logic [63:0] regs_in = '0;
  logic mem_block, rd_bit, wr_strobe;
  logic [63:0] wr_data;

  int checks = 0, failures = 0, strobes = 0, cycles = 0;
  logic   rd_q[$];
  logic [63:0] wd_q[$];
  string  rd_tag;
  event   smp;

  always #2.5 clk = ~clk;

  serial_unlock_ctrl i_serial_unlock_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .dq0(dq0),
    .rst_pin_n(rst_pin_n), .rst_en_ignore(rst_en_ignore), .regs_in(regs_in),
    .mem_block(mem_block), .rd_bit(rd_bit), .wr_data(wr_data),
    .wr_strobe(wr_strobe)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: read-data bits, compared against the scoreboard queue.
  always @(smp) begin
    logic e;
    e = rd_q.pop_front();
    chk(rd_bit === e, rd_tag, 64'(rd_bit), 64'(e));
  end

  // Monitor: commits, compared against expected images.
  always @(negedge clk) begin
    if (!rst && wr_strobe === 1'b1) begin
      strobes++;
      if (wd_q.size() == 0) chk(1'b0, "R8 unexpected commit", wr_data, '0);
      else begin
        logic [63:0] e;
        e = wd_q.pop_front();
        chk(wr_data === e, "R7 commit image", wr_data, e);
      end
    end
  end

  task automatic bus_op(input bit is_wr, input bit d, input bit sel = 1'b1);
    @(negedge clk);
    cs_n = ~sel; we_n = ~is_wr; oe_n = is_wr; dq0 = d;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_expect(input bit e, input string tag);
    @(negedge clk);
    rd_tag = tag;
    rd_q.push_back(e);
    -> smp;
    bus_op(1'b0, 1'b0);
  endtask

  task automatic send_key();
    for (int k = 0; k < 64; k++) bus_op(1'b1, KEYV[k]);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] snap, pat, exp;
    int sc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_block === 1'b0 && wr_strobe === 1'b0 && rd_bit === 1'b0,
        "R1 reset state", {61'd0, mem_block, wr_strobe, rd_bit}, '0);

    // R3: mismatch at bit 5, then a full key without a read must not unlock.
    bus_op(1'b0, 1'b0);
    for (int k = 0; k < 5; k++) bus_op(1'b1, KEYV[k]);
    bus_op(1'b1, ~KEYV[5]);
    send_key();
    chk(mem_block === 1'b0, "R3 sticky mismatch", 64'(mem_block), 64'd0);

    // R4: partial key, read, then a full key with deselected strobes (R11).
    for (int k = 0; k < 30; k++) bus_op(1'b1, KEYV[k]);
    bus_op(1'b0, 1'b0);
    for (int k = 0; k < 64; k++) begin
      bus_op(1'b1, KEYV[k]);
      if (k % 9 == 4) bus_op(1'b1, ~KEYV[k + 1], 1'b0);  // R11 chip-enable high
      if (k == 40) chk(mem_block === 1'b0, "R5 no inhibit mid key", 64'(mem_block), 64'd0);
    end
    chk(mem_block === 1'b1, "R4 R11 unlock after read", 64'(mem_block), 64'd1);

    // R6: read transfer, snapshot taken at unlock. Already unlocked with regs_in.
    // Finish with reads; snapshot was regs_in = 0 here.
    for (int i = 0; i < 64; i++) rd_expect(1'b0, "R6 zero snapshot bit");
    chk(mem_block === 1'b0 && strobes == 0, "R8 read-only no commit",
        64'(strobes), 64'd0);
    chk(rd_bit === 1'b0, "R6 rd_bit idle", 64'(rd_bit), 64'd0);

    // R6 with a changing source.
    snap = 64'hDEADBEEF_0123A5C3;
    regs_in = snap;
    send_key();
    regs_in = ~snap;
    for (int i = 0; i < 64; i++) rd_expect(snap[i], "R6 snapshot bit");
    @(negedge clk);

    // R7 + R12: pure write transfer.
    pat = 64'h0F1E2D3C_4B5A6978;
    send_key();
    wd_q.push_back(pat);
    sc = strobes;
    for (int i = 0; i < 63; i++) bus_op(1'b1, pat[i]);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; dq0 = pat[63];
    repeat (2) @(negedge clk);
    chk(mem_block === 1'b1, "R12 inhibit held while strobed", 64'(mem_block), 64'd1);
    chk(wr_strobe === 1'b1, "R7 commit at last cycle", 64'(wr_strobe), 64'd1);
    cs_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_block === 1'b0, "R12 inhibit released", 64'(mem_block), 64'd0);
    chk(strobes == sc + 1, "R7 single commit", 64'(strobes), 64'(sc + 1));

    // R8: mixed transfer, even positions written, odd read.
    snap = 64'hA5A5_3C3C_F00F_1234;
    regs_in = snap;
    pat = 64'h6B2C_91E7_05DA_C3F8;
    send_key();
    exp = snap;
    for (int i = 0; i < 64; i += 2) exp[i] = pat[i];
    wd_q.push_back(exp);
    sc = strobes;
    for (int i = 0; i < 64; i++) begin
      if (i % 2 == 0) bus_op(1'b1, pat[i]);
      else rd_expect(snap[i], "R8 mixed read bit");
    end
    chk(strobes == sc + 1, "R8 mixed commit count", 64'(strobes), 64'(sc + 1));

    // R9: abort mid transfer.
    send_key();
    sc = strobes;
    for (int i = 0; i < 10; i++) bus_op(1'b1, 1'b1);
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_block === 1'b0, "R9 abort drops inhibit", 64'(mem_block), 64'd0);
    for (int i = 0; i < 54; i++) bus_op(1'b1, 1'b1);
    chk(strobes == sc && mem_block === 1'b0, "R9 abort no commit",
        64'(strobes), 64'(sc));

    // R10 + R12: reset pin ignored, key works again after the abort.
    rst_en_ignore = 1'b1;
    pat = 64'hFFFF_0000_8001_7FFE;
    bus_op(1'b0, 1'b0);
    send_key();
    chk(mem_block === 1'b1, "R12 relock after return", 64'(mem_block), 64'd1);
    wd_q.push_back(pat);
    sc = strobes;
    for (int i = 0; i < 64; i++) begin
      if (i == 20) rst_pin_n = 1'b0;
      bus_op(1'b1, pat[i]);
    end
    rst_pin_n = 1'b1;
    chk(strobes == sc + 1, "R10 pin ignored commit", 64'(strobes), 64'(sc + 1));
    chk(wd_q.size() == 0, "R7 all commits seen", 64'(wd_q.size()), 64'd0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule